// File: doc/BRIEF.md
# Bit-serial CRC-8 unit for 1-Wire identifiers

This block computes and checks the 8-bit cyclic redundancy code used on 1-Wire registration numbers and data streams. It processes one bit per accepted clock cycle. Bits are taken least-significant first, and the generator polynomial is x^8 + x^5 + x^4 + 1. The running remainder is held in an 8-bit register, which is exposed together with a flag that goes high when that register is all zeros.

There are two ways to use it. To generate a code, the caller clears the register and shifts in the 56 bits made of the family byte and the 48-bit serial number. The register then holds the byte that belongs in the top eight bits of the 64-bit number. To check a received number, the caller clears the register and shifts in all 64 bits, code byte included. A correct number leaves a zero residue, and the zero flag then reports a valid number. The zero flag only has meaning once the full 64 bits have been fed.

Top module: `owcrc8`

## Requirements
- R1: While `rst` is high at a rising clock edge, the register becomes 8'h00 after that edge, and `crc_zero` reads 1.
- R2: A cycle with `clr` high sets the register to 8'h00 after the edge.
- R3: When `clr` and `bit_vld` are both high in the same cycle, the clear wins: the register becomes 8'h00 and the data bit is discarded.
- R4: A cycle with `bit_vld` low and `clr` low leaves the register unchanged, whatever the value on `bit_din`.
- R5: An accepted bit updates the register as follows. The feedback is fb = bit_din XOR crc[0]. The register shifts right by one, filling bit 7 with 0, and is then XORed with 8'h8C when fb is 1. Bit 0 of the register is the next bit to leave.
- R6: After a clear, feeding the 56 bits of the bytes 02,1C,B8,01,00,00,00 (each byte LSB first, first byte first) leaves the register at 8'hA2.
- R7: Feeding any 56 data bits followed by the 8 bits of their own code (LSB first) leaves the register at 8'h00, and `crc_zero` at 1.
- R8: Feeding a 64-bit number in which one bit has been flipped leaves a nonzero register, and `crc_zero` at 0.
- R9: `crc_zero` is 1 exactly when the register `crc_q` equals 8'h00, in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous clear of the remainder, takes priority over a bit |
| bit_vld | input | 1 | Qualifies `bit_din` for one update |
| bit_din | input | 1 | Serial data bit, LSB first |
| crc_q | output | 8 | Current remainder register |
| crc_zero | output | 1 | High when `crc_q` is zero |

## Verification
The clear and a qualified bit can arrive in the same cycle. The bench provokes this partway through a 64-bit stream by raising `clr` and `bit_vld` together, once with a data bit that would set the top bit of the register. It judges the outcome by requiring an all-zero register and a high zero flag after the edge. The bench also checks that the very next accepted bit starts from a clean remainder, as predicted by an independent MSB-first model of the division.

// File: rtl/owcrc_pkg.sv
package owcrc_pkg;
  // Register width and the reflected form of x^8 + x^5 + x^4 + 1.
  localparam int unsigned CRC_W          = 8;
  localparam logic [CRC_W-1:0] POLY_REFL = 8'h8C;
  localparam logic [CRC_W-1:0] CRC_INIT  = '0;

  typedef logic [CRC_W-1:0] crc_t;
endpackage

// File: rtl/owcrc_step.sv
// One LSB-first update of the reflected remainder.
module owcrc_step #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] POLY = 8'h8C
) (
  input  logic [W-1:0] cur,
  input  logic         din,
  output logic [W-1:0] nxt
);
  logic fb;

  always_comb begin
    fb  = din ^ cur[0];
    nxt = {1'b0, cur[W-1:1]} ^ (fb ? POLY : '0);
  end
endmodule

// File: rtl/owcrc_zero_det.sv
// NOR reduction built as an explicit chain.
module owcrc_zero_det #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] val,
  output logic         is_zero
);
  logic [W:0] any_set;

  assign any_set[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_or
    assign any_set[i+1] = any_set[i] | val[i];
  end

  assign is_zero = ~any_set[W];
endmodule

// File: rtl/owcrc8.sv
module owcrc8
  import owcrc_pkg::*;
#(
  parameter int unsigned W = CRC_W,
  parameter logic [W-1:0] POLY = POLY_REFL
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         bit_vld,
  input  logic         bit_din,
  output logic [W-1:0] crc_q,
  output logic         crc_zero
);
  logic [W-1:0] crc_r;
  logic [W-1:0] crc_nxt;

  owcrc_step #(.W(W), .POLY(POLY)) step_i (
    .cur (crc_r),
    .din (bit_din),
    .nxt (crc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      crc_r <= '0;
    end else if (bit_vld) begin
      crc_r <= crc_nxt;
    end
  end

  owcrc_zero_det #(.W(W)) zdet_i (
    .val     (crc_r),
    .is_zero (crc_zero)
  );

  assign crc_q = crc_r;
endmodule

// File: rtl/owcrc8_chk.sv
module owcrc8_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         clr,
  input logic         bit_vld,
  input logic         bit_din,
  input logic [W-1:0] crc_q,
  input logic         crc_zero
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (crc_q == '0) && crc_zero);

  a_r2_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (crc_q == '0));

  a_r3_clear_beats_bit: assert property (@(posedge clk) disable iff (rst)
    (clr && bit_vld) |=> crc_zero);

  a_r4_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!clr && !bit_vld) |=> $stable(crc_q));

  a_r5_no_feedback: assert property (@(posedge clk) disable iff (rst)
    (!clr && bit_vld && (bit_din == crc_q[0])) |=> (crc_q == ($past(crc_q) >> 1)));

  a_r5_feedback_top: assert property (@(posedge clk) disable iff (rst)
    (!clr && bit_vld && (bit_din != crc_q[0])) |=> crc_q[W-1]);

  a_r9_flag_tracks: assert property (@(posedge clk) disable iff (rst)
    crc_zero |-> ($countones(crc_q) == 0));
endmodule

bind owcrc8 owcrc8_chk #(.W(W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .clr      (clr),
  .bit_vld  (bit_vld),
  .bit_din  (bit_din),
  .crc_q    (crc_q),
  .crc_zero (crc_zero)
);

// File: tb/owcrc8_tb_top.sv
module owcrc8_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0;
  logic bit_vld = 1'b0;
  logic bit_din = 1'b0;
  logic [7:0] crc_q;
  logic crc_zero;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp_crc;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  // Independent model: MSB-first division by 0x131, result read bit-reversed.
  logic [7:0] mdl = 8'h00;

  always #2 clk = ~clk;

  owcrc8 dut_i (
    .clk(clk), .rst(rst), .clr(clr), .bit_vld(bit_vld), .bit_din(bit_din),
    .crc_q(crc_q), .crc_zero(crc_zero)
  );

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic v, input logic d, input string tag);
    exp_t e;
    @(negedge clk);
    clr = c; bit_vld = v; bit_din = d;
    if (c) mdl = 8'h00;
    else if (v) begin
      logic fb;
      fb  = d ^ mdl[7];
      mdl = {mdl[6:0], 1'b0} ^ (fb ? 8'h31 : 8'h00);
    end
    e.exp_crc = rev8(mdl);
    e.tag = tag;
    sb_q.push_back(e);
    @(posedge clk);
    #1;
    clr = 1'b0; bit_vld = 1'b0;
  endtask

  task automatic feed_byte(input logic [7:0] b, input string tag);
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, b[i], tag);
  endtask

  // Monitor: compare each scheduled result one step after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #0.5;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " crc"}, crc_q, e.exp_crc);
        check("R9 zero flag", {7'd0, crc_zero}, {7'd0, (e.exp_crc == 8'h00)});
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] id_a [7];
    logic [7:0] id_b [7];
    logic [7:0] code_b;
    id_a = '{8'h02, 8'h1C, 8'hB8, 8'h01, 8'h00, 8'h00, 8'h00};
    id_b = '{8'h3A, 8'h5E, 8'h91, 8'h0F, 8'hC4, 8'h27, 8'h6B};

    repeat (3) @(posedge clk);
    #1;
    check("R1 reset crc", crc_q, 8'h00);
    check("R1 reset zero", {7'd0, crc_zero}, 8'h01);
    @(negedge clk);
    rst = 1'b0;

    // R6: generate code over 56 bits of the known identifier.
    step(1'b1, 1'b0, 1'b0, "R2");
    for (int k = 0; k < 7; k++) feed_byte(id_a[k], "R5");
    #1;
    check("R6 known code", crc_q, 8'hA2);

    // R4: idle cycles with toggling data must not move the register.
    step(1'b0, 1'b0, 1'b1, "R4");
    step(1'b0, 1'b0, 1'b0, "R4");
    #1;
    check("R4 hold", crc_q, 8'hA2);

    // R7: append the code byte, zero residue expected.
    feed_byte(8'hA2, "R7");
    #1;
    check("R7 residue", crc_q, 8'h00);
    check("R7 zero flag", {7'd0, crc_zero}, 8'h01);

    // R2/R3: clear mid-stream, then clear coinciding with a bit.
    feed_byte(8'h5D, "R5");
    step(1'b1, 1'b0, 1'b0, "R2");
    #1;
    check("R2 clear", crc_q, 8'h00);
    feed_byte(8'hE7, "R5");
    step(1'b1, 1'b1, ~crc_q[0], "R3");
    #1;
    check("R3 clear wins", crc_q, 8'h00);
    step(1'b0, 1'b1, 1'b1, "R3 first bit after clear");
    #1;
    check("R3 fresh start", crc_q, 8'h8C);

    // Second identifier: code from the model, then check the residue.
    step(1'b1, 1'b0, 1'b0, "R2");
    for (int k = 0; k < 7; k++) feed_byte(id_b[k], "R5");
    code_b = crc_q;
    #1;
    check("R7 model code", crc_q, rev8(mdl));
    feed_byte(code_b, "R7");
    #1;
    check("R7 residue 2", crc_q, 8'h00);

    // R8: one flipped bit in the serial number must be detected.
    step(1'b1, 1'b0, 1'b0, "R2");
    for (int k = 0; k < 7; k++) feed_byte((k == 3) ? (id_b[k] ^ 8'h10) : id_b[k], "R8");
    feed_byte(code_b, "R8");
    #1;
    n_checks++;
    if (crc_q == 8'h00 || crc_zero !== 1'b0) begin
      n_errors++;
      $display("FAIL R8 corrupted number: actual %h/%b expected nonzero/0", crc_q, crc_zero);
    end

    repeat (2) @(posedge clk);
    #1;
    check("scoreboard drained", 8'(sb_q.size()), 8'h00);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule